// File: doc/BRIEF.md
# Two-Word Event Item Formatter

The formatter turns time-stamped events from five internal sources into a stream of 32-bit words for a data-acquisition link. The sources are a sync pulse, a flow-control pause, a flow-control resume, a group A pattern hit and a group B pattern hit. Each source presents a level request together with a 48-bit timestamp. The two group sources also present a 16-bit pattern. Every event becomes one item of exactly two words, and the words leave through a valid/ready stream.

A pattern item carries a 12-bit source ident that software sets separately for each group. An information item (sync, pause, resume) carries a 6-bit module number, a 4-bit information code and the top twenty timestamp bits. The second word of either kind holds the low 28 timestamp bits. When several requests are up at once, a fixed priority picks the next one. A source keeps its request raised until the block returns a one-cycle acknowledge for it. That acknowledge marks the moment its second word is taken.

Top module: `evt_item_fmt`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_valid` is low and `src_ack` is all zero.
- R2: The first word of a pattern item is {4'b1100, ident[11:0], pattern[15:0]}. Group A uses `ident_a`/`pat_a` (request bit 3). Group B uses `ident_b`/`pat_b` (request bit 4).
- R3: The first word of an information item is {2'b10, module[5:0], code[3:0], ts[47:28]}. The code is 4 for sync (request bit 0), 2 for pause (bit 1) and 3 for resume (bit 2).
- R4: The second word of every item is {4'b0000, ts[27:0]}, using the timestamp of the source that won.
- R5: When several requests are high as an item starts, the lowest set request bit wins. The resulting order is sync, pause, resume, group A, group B.
- R6: The two words of an item are sent back to back, with no word of another item between them. A request that rises while an item is in flight waits, even if its priority is higher.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R8: `src_ack` has at most one bit set. That bit is the winning source's bit, and it is high only in the cycle in which the second word is accepted. No acknowledge is given while the first word is out or while the stream is stalled.
- R9: With no request high, `out_valid` stays low. After an item's second word is accepted, `out_valid` is low for exactly one cycle before the next item's first word appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| module_num | input | 6 | Module number placed in information items |
| ident_a | input | 12 | Source ident for group A pattern items |
| ident_b | input | 12 | Source ident for group B pattern items |
| src_req | input | 5 | Request per source: bit 0 sync, 1 pause, 2 resume, 3 group A, 4 group B |
| src_ts | input | 240 | Timestamps, 48 bits per source; source i in bits 48*i+47 down to 48*i |
| pat_a | input | 16 | Group A pattern |
| pat_b | input | 16 | Group B pattern |
| src_ack | output | 5 | One-cycle acknowledge per source, given when its item completes |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Output word accepted when high with out_valid |
| out_data | output | 32 | Output word |

## Verification
The bench raises all five requests in the same cycle. It then checks the order of the acknowledges and of the first words, because a wrong priority chain would reorder the items or emit a lower source first. It also raises the sync request after group B's first word has gone out. A design that re-arbitrated between the two words would then insert the sync item in the middle of group B's item. Several timestamps are chosen so that bits 27 and 28 differ. This exposes a split of the timestamp at the wrong bit, or tail and field bits taken from the wrong slice. A stalled stream is held for several cycles to catch a word that changes, or an acknowledge that fires early, while `out_ready` is low.

// File: rtl/evt_fmt_pkg.sv
package evt_fmt_pkg;

    localparam int NSRC   = 5;
    localparam int TSW    = 48;
    localparam int PATW   = 16;
    localparam int IDW    = 12;
    localparam int MODW   = 6;
    localparam int CODEW  = 4;
    localparam int WORDW  = 32;
    localparam int LOWTS  = 28;
    localparam int HIGHTS = TSW - LOWTS;
    localparam int SRCIW  = $clog2(NSRC);

    typedef enum logic [SRCIW-1:0] {
        SRC_SYNC   = 3'd0,
        SRC_PAUSE  = 3'd1,
        SRC_RESUME = 3'd2,
        SRC_GRPA   = 3'd3,
        SRC_GRPB   = 3'd4
    } src_e;

    localparam logic [CODEW-1:0] INFO_UNDEF  = 4'd0;
    localparam logic [CODEW-1:0] INFO_PAUSE  = 4'd2;
    localparam logic [CODEW-1:0] INFO_RESUME = 4'd3;
    localparam logic [CODEW-1:0] INFO_SYNC   = 4'd4;

    localparam logic [3:0] TAG_PATTERN = 4'b1100;
    localparam logic [1:0] TAG_INFO    = 2'b10;
    localparam logic [3:0] TAG_TIME    = 4'b0000;

    typedef struct packed {
        logic [WORDW-1:0] head;
        logic [WORDW-1:0] tail;
    } item_t;

    typedef enum logic [1:0] {
        EM_IDLE = 2'd0,
        EM_HEAD = 2'd1,
        EM_TAIL = 2'd2
    } emit_e;

    function automatic logic [WORDW-1:0] pattern_head(
        input logic [IDW-1:0]  ident,
        input logic [PATW-1:0] pat
    );
        return {TAG_PATTERN, ident, pat};
    endfunction

    function automatic logic [WORDW-1:0] info_head(
        input logic [MODW-1:0]  modnum,
        input logic [CODEW-1:0] code,
        input logic [TSW-1:0]   ts
    );
        return {TAG_INFO, modnum, code, ts[TSW-1:LOWTS]};
    endfunction

    function automatic logic [WORDW-1:0] time_tail(input logic [TSW-1:0] ts);
        return {TAG_TIME, ts[LOWTS-1:0]};
    endfunction

endpackage

// File: rtl/evt_prio_arb.sv
module evt_prio_arb #(
    parameter int N = 5
) (
    input  logic [N-1:0]         req,
    output logic                 any,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IW = $clog2(N);

    logic [N-1:0] higher;
    logic [N-1:0] grant;

    assign higher[0] = 1'b0;
    genvar g;
    generate
        for (g = 1; g < N; g++) begin : g_chain
            assign higher[g] = higher[g-1] | req[g-1];
        end
    endgenerate

    assign grant = req & ~higher;
    assign any   = |req;

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/evt_word_build.sv
module evt_word_build
    import evt_fmt_pkg::*;
(
    input  logic [SRCIW-1:0]    idx,
    input  logic [NSRC*TSW-1:0] ts_flat,
    input  logic [PATW-1:0]     pat_a,
    input  logic [PATW-1:0]     pat_b,
    input  logic [IDW-1:0]      ident_a,
    input  logic [IDW-1:0]      ident_b,
    input  logic [MODW-1:0]     modnum,
    output item_t               item
);
    logic [TSW-1:0] ts;

    always_comb begin
        ts = ts_flat[idx*TSW +: TSW];
        item.tail = time_tail(ts);
        case (src_e'(idx))
            SRC_GRPA:   item.head = pattern_head(ident_a, pat_a);
            SRC_GRPB:   item.head = pattern_head(ident_b, pat_b);
            SRC_SYNC:   item.head = info_head(modnum, INFO_SYNC, ts);
            SRC_PAUSE:  item.head = info_head(modnum, INFO_PAUSE, ts);
            SRC_RESUME: item.head = info_head(modnum, INFO_RESUME, ts);
            default:    item.head = info_head(modnum, INFO_UNDEF, ts);
        endcase
    end
endmodule

// File: rtl/evt_emit_seq.sv
module evt_emit_seq
    import evt_fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              any,
    input  logic [SRCIW-1:0]  idx_in,
    input  item_t             item_in,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [WORDW-1:0]  out_data,
    output logic [NSRC-1:0]   ack
);
    emit_e            state_q;
    logic [SRCIW-1:0] idx_q;
    item_t            item_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= EM_IDLE;
            idx_q   <= '0;
            item_q  <= '0;
        end else begin
            case (state_q)
                EM_IDLE: if (any) begin
                    item_q  <= item_in;
                    idx_q   <= idx_in;
                    state_q <= EM_HEAD;
                end
                EM_HEAD: if (out_ready) state_q <= EM_TAIL;
                EM_TAIL: if (out_ready) state_q <= EM_IDLE;
                default: state_q <= EM_IDLE;
            endcase
        end
    end

    assign out_valid = (state_q != EM_IDLE);
    assign out_data  = (state_q == EM_TAIL) ? item_q.tail : item_q.head;

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_ack
            assign ack[g] = (state_q == EM_TAIL) && out_ready && (idx_q == SRCIW'(g));
        end
    endgenerate
endmodule

// File: rtl/evt_item_fmt.sv
module evt_item_fmt
    import evt_fmt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [MODW-1:0]     module_num,
    input  logic [IDW-1:0]      ident_a,
    input  logic [IDW-1:0]      ident_b,
    input  logic [NSRC-1:0]     src_req,
    input  logic [NSRC*TSW-1:0] src_ts,
    input  logic [PATW-1:0]     pat_a,
    input  logic [PATW-1:0]     pat_b,
    output logic [NSRC-1:0]     src_ack,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [WORDW-1:0]    out_data
);
    logic             any;
    logic [SRCIW-1:0] win_idx;
    item_t            win_item;

    evt_prio_arb #(.N(NSRC)) u_arb (
        .req (src_req),
        .any (any),
        .idx (win_idx)
    );

    evt_word_build u_build (
        .idx     (win_idx),
        .ts_flat (src_ts),
        .pat_a   (pat_a),
        .pat_b   (pat_b),
        .ident_a (ident_a),
        .ident_b (ident_b),
        .modnum  (module_num),
        .item    (win_item)
    );

    evt_emit_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .any       (any),
        .idx_in    (win_idx),
        .item_in   (win_item),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .ack       (src_ack)
    );
endmodule

// File: rtl/evt_item_fmt_chk.sv
module evt_item_fmt_chk (
    input logic        clk,
    input logic        rst,
    input logic [4:0]  src_req,
    input logic [4:0]  src_ack,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data
);
    // Word position inside the current item, tracked from the handshakes alone
    logic second;
    always_ff @(posedge clk) begin
        if (rst) second <= 1'b0;
        else if (out_valid && out_ready) second <= ~second;
    end

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_ack_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_ack));

    assert_ack_on_second_R8: assert property (@(posedge clk) disable iff (rst)
        (|src_ack) |-> (second && out_valid && out_ready));

    assert_ack_has_req_R8: assert property (@(posedge clk) disable iff (rst)
        (|src_ack) |-> ((src_ack & ~src_req) == 5'b0));

    assert_tail_tag_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && second) |-> (out_data[31:28] == 4'b0000));

    assert_head_tag_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !second) |-> out_data[31]);

    assert_gap_R9: assert property (@(posedge clk) disable iff (rst)
        (|src_ack) |=> !out_valid);
endmodule

bind evt_item_fmt evt_item_fmt_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_req   (src_req),
    .src_ack   (src_ack),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/tb_evt_item_fmt.sv
module tb_evt_item_fmt;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [5:0]   module_num = 6'h2D;
    logic [11:0]  ident_a = 12'h3E1;
    logic [11:0]  ident_b = 12'h5A7;
    logic [4:0]   src_req = '0;
    logic [47:0]  ts_v [5];
    logic [239:0] src_ts;
    logic [15:0]  pat_a = 16'hA5C3;
    logic [15:0]  pat_b = 16'h0F1E;
    logic [4:0]   src_ack;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [31:0]  out_data;

    assign src_ts = {ts_v[4], ts_v[3], ts_v[2], ts_v[1], ts_v[0]};

    always #10 clk = ~clk;

    evt_item_fmt dut (
        .clk(clk), .rst(rst), .module_num(module_num), .ident_a(ident_a),
        .ident_b(ident_b), .src_req(src_req), .src_ts(src_ts), .pat_a(pat_a),
        .pat_b(pat_b), .src_ack(src_ack), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] got [0:15];
    int          got_cyc [0:15];
    logic [4:0]  got_ack [0:7];
    int          n_got, n_ack;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] e_pat(input logic [11:0] id, input logic [15:0] p);
        return {4'b1100, id, p};
    endfunction
    function automatic logic [31:0] e_info(input logic [3:0] code, input logic [47:0] ts);
        return {2'b10, module_num, code, ts[47:28]};
    endfunction
    function automatic logic [31:0] e_tail(input logic [47:0] ts);
        return {4'b0000, ts[27:0]};
    endfunction

    // Accepts nitems items; stall_mod>0 drops ready every stall_mod-th cycle.
    // inj_mask is raised once, right after inj_after words have been taken.
    task automatic drain(input int nitems, input int stall_mod, input int inj_after, input logic [4:0] inj_mask);
        int n = 0;
        int na = 0;
        int cyc = 0;
        bit injected = 0;
        logic [4:0] a;
        logic hs;
        while (n < 2 * nitems && cyc < 300) begin
            @(negedge clk);
            out_ready = (stall_mod == 0) ? 1'b1 : ((cyc % stall_mod) != 0);
            #1;
            hs = out_valid && out_ready;
            a = src_ack;
            if (hs) begin
                got[n] = out_data;
                got_cyc[n] = cyc;
                n++;
            end
            if (|a) begin
                got_ack[na] = a;
                na++;
                chk(hs && (n % 2 == 0), "R8 ack only with second word", {31'd0, hs}, 32'd1);
            end
            cyc++;
            @(posedge clk);
            #1;
            src_req = src_req & ~a;
            if (!injected && inj_mask != 0 && n == inj_after) begin
                src_req = src_req | inj_mask;
                injected = 1;
            end
        end
        chk(n == 2 * nitems, "R9 words delivered", n, 2 * nitems);
        out_ready = 1'b0;
        n_got = n;
        n_ack = na;
    endtask

    task automatic t_reset;
        chk(out_valid == 1'b0, "R1 valid in reset", {31'd0, out_valid}, 0);
        chk(src_ack == 5'd0, "R1 ack in reset", {27'd0, src_ack}, 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0 && src_ack == 0, "R1 after reset", {31'd0, out_valid}, 0);
        repeat (5) @(negedge clk);
        chk(out_valid == 1'b0, "R9 idle without request", {31'd0, out_valid}, 0);
    endtask

    task automatic t_group_a;
        ts_v[3] = 48'h1234_5678_9ABC;
        src_req = 5'b01000;
        drain(1, 0, 0, 5'd0);
        chk(got[0] == e_pat(ident_a, pat_a), "R2 group A head", got[0], e_pat(ident_a, pat_a));
        chk(got[1] == e_tail(ts_v[3]), "R4 group A tail", got[1], e_tail(ts_v[3]));
        chk(got_ack[0] == 5'b01000, "R8 group A ack", {27'd0, got_ack[0]}, 32'h8);
    endtask

    task automatic t_group_b_stalled;
        ts_v[4] = 48'h0000_1800_0000;
        src_req = 5'b10000;
        drain(1, 3, 0, 5'd0);
        chk(got[0] == e_pat(ident_b, pat_b), "R2 group B head", got[0], e_pat(ident_b, pat_b));
        chk(got[1] == e_tail(ts_v[4]), "R4 group B tail", got[1], e_tail(ts_v[4]));
    endtask

    task automatic t_info;
        ts_v[0] = 48'hFFFF_F000_0001;
        ts_v[1] = 48'h8000_0FFF_FFFF;
        ts_v[2] = 48'h0ABC_DEF0_1234;
        src_req = 5'b00001;
        drain(1, 0, 0, 5'd0);
        chk(got[0] == e_info(4'd4, ts_v[0]), "R3 sync head", got[0], e_info(4'd4, ts_v[0]));
        chk(got[1] == e_tail(ts_v[0]), "R4 sync tail", got[1], e_tail(ts_v[0]));
        src_req = 5'b00010;
        drain(1, 0, 0, 5'd0);
        chk(got[0] == e_info(4'd2, ts_v[1]), "R3 pause head", got[0], e_info(4'd2, ts_v[1]));
        chk(got[1] == e_tail(ts_v[1]), "R4 pause tail", got[1], e_tail(ts_v[1]));
        src_req = 5'b00100;
        drain(1, 2, 0, 5'd0);
        chk(got[0] == e_info(4'd3, ts_v[2]), "R3 resume head", got[0], e_info(4'd3, ts_v[2]));
        chk(got[1] == e_tail(ts_v[2]), "R4 resume tail", got[1], e_tail(ts_v[2]));
    endtask

    task automatic t_priority;
        logic [31:0] exp_head [5];
        exp_head[0] = e_info(4'd4, ts_v[0]);
        exp_head[1] = e_info(4'd2, ts_v[1]);
        exp_head[2] = e_info(4'd3, ts_v[2]);
        exp_head[3] = e_pat(ident_a, pat_a);
        exp_head[4] = e_pat(ident_b, pat_b);
        src_req = 5'b11111;
        drain(5, 0, 0, 5'd0);
        for (int k = 0; k < 5; k++) begin
            chk(got_ack[k] == 5'(1 << k), "R5 acknowledge order", {27'd0, got_ack[k]}, 32'(1 << k));
            chk(got[2*k] == exp_head[k], "R5 head order", got[2*k], exp_head[k]);
            chk(got[2*k+1] == e_tail(ts_v[k]), "R6 tail follows its head", got[2*k+1], e_tail(ts_v[k]));
        end
        chk(got_cyc[2] - got_cyc[1] == 2, "R9 one idle cycle between items", got_cyc[2] - got_cyc[1], 2);
    endtask

    task automatic t_no_preempt;
        src_req = 5'b10000;
        drain(2, 0, 1, 5'b00001);
        chk(got[1] == e_tail(ts_v[4]), "R6 group B tail not split", got[1], e_tail(ts_v[4]));
        chk(got[2] == e_info(4'd4, ts_v[0]), "R6 sync waits", got[2], e_info(4'd4, ts_v[0]));
        chk(got_ack[0] == 5'b10000 && got_ack[1] == 5'b00001, "R6 ack order", {27'd0, got_ack[0]}, 32'h10);
    endtask

    task automatic t_stall_hold;
        logic [31:0] d0;
        src_req = 5'b01000;
        out_ready = 1'b0;
        @(negedge clk); @(negedge clk);
        d0 = out_data;
        chk(out_valid && d0 == e_pat(ident_a, pat_a), "R7 stalled head shown", d0, e_pat(ident_a, pat_a));
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(out_valid && out_data == d0, "R7 held under stall", out_data, d0);
            chk(src_ack == 0, "R8 no ack while stalled", {27'd0, src_ack}, 0);
        end
        drain(1, 0, 0, 5'd0);
        chk(got[0] == d0 && got[1] == e_tail(ts_v[3]), "R7 words after stall", got[1], e_tail(ts_v[3]));
    endtask

    bit done = 0;
    initial begin
        ts_v[0] = '0; ts_v[1] = '0; ts_v[2] = '0; ts_v[3] = '0; ts_v[4] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        t_group_a();
        t_group_b_stalled();
        t_info();
        t_priority();
        t_no_preempt();
        t_stall_hold();
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R9 idle at end", {31'd0, out_valid}, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R9 actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule